// File: doc/BRIEF.md
# Lane Striper with Alignment Markers

This block takes one stream of 66-bit line-coded blocks and deals them out to a parameterised number of lanes in a fixed rotation. A block is never split: the whole block goes to one lane, so lane k carries aggregate blocks k, k+LANES, k+2*LANES and so on. The default lane count of 20 suits the case where it is chosen as the least common multiple of the electrical and optical lane counts.

So that a receiver can tell the lanes apart and remove skew between them, every lane regularly carries an alignment marker. This is a 66-bit control block with a payload unique to that lane. All lanes get their markers in the same rotation. That marker rotation comes once every MARK_PERIOD rotations, which defaults to 16384 and can be made small for testing. While the marker rotation runs, the input is held off, so no data block is dropped.

The output is one block per cycle. It carries the lane index it belongs to and goes through a registered stage. A downstream lane buffer or bit multiplexer picks the block up by its lane index.

Top module: `lane_stripe_marker`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_valid` is 0 and `in_ready` is 0. Reset is synchronous and active high.
- R2: The first rotation after reset is a marker rotation. It emits LANES markers for lanes 0, 1, …, LANES-1, one per cycle.
- R3: A marker for lane L has `out_block[65:64]` = 2'b10. Its payload `out_block[63:0]` is built from the byte l = L[7:0] as {8'hA5, l, ~l, l, ~l, l, ~l, l}, with the most significant byte first.
- R4: `in_ready` is 0 for exactly the LANES cycles of each marker rotation and 1 at all other times outside reset. A block offered while `in_ready` is 0 is not taken.
- R5: A block accepted (`in_valid` and `in_ready` both 1) appears unchanged on `out_block` one clock later, with `out_valid` high.
- R6: Successive emitted blocks take lane indices 0, 1, …, LANES-1, 0, … with no skip. A data-rotation cycle without `in_valid` emits nothing and does not advance the lane.
- R7: After each marker rotation come exactly MARK_PERIOD-1 data rotations, that is LANES*(MARK_PERIOD-1) accepted blocks, and then the next marker rotation. Each lane therefore carries one marker per MARK_PERIOD blocks.
- R8: Data blocks leave in the order they were accepted, with none lost and none repeated.
- R9: Markers of one rotation are emitted in consecutive cycles, whatever the value of `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block offered |
| in_block | input | 66 | Input block: [65:64] sync header, [63:0] payload |
| in_ready | output | 1 | Block taken this cycle when in_valid is high |
| out_valid | output | 1 | Output block present |
| out_lane | output | $clog2(LANES) | Lane index of the output block |
| out_block | output | 66 | Output block (data or alignment marker) |

## Verification
Two functions meet in one cycle: the last data slot of a rotation is accepted, and in that same cycle the rotation counter moves to the marker phase, so `in_ready` must drop without losing or doubling that block. The bench provokes this by holding `in_valid` high across every marker boundary and by reaching the boundary with a pseudo-random valid pattern. A behavioural model that indexes the emitted blocks by count judges each cycle: it compares the ready level, the lane, and whether the block is the marker or the next queued input.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
  localparam int BLK_W = 66;
  localparam int PAY_W = 64;
  localparam logic [1:0] SYNC_CTRL = 2'b10;
  localparam logic [7:0] MARK_TYPE = 8'hA5;

  function automatic logic [PAY_W-1:0] marker_payload(input int unsigned lane);
    logic [7:0] l;
    l = lane[7:0];
    return {MARK_TYPE, l, ~l, l, ~l, l, ~l, l};
  endfunction
endpackage

// File: rtl/stripe_sequencer.sv
module stripe_sequencer #(
  parameter int LANES  = 20,
  parameter int PERIOD = 16384,
  localparam int LANE_W = $clog2(LANES),
  localparam int ROT_W  = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [LANE_W-1:0] slot,
  output logic              marker_phase
);
  logic [ROT_W-1:0] rot;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
      rot  <= '0;
    end else if (advance) begin
      if (slot == LANE_W'(LANES - 1)) begin
        slot <= '0;
        rot  <= (rot == ROT_W'(PERIOD - 1)) ? '0 : rot + 1'b1;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  assign marker_phase = (rot == '0);
endmodule

// File: rtl/stripe_marker_gen.sv
module stripe_marker_gen #(
  parameter int LANES = 20,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0]               sel,
  output logic [stripe_pkg::BLK_W-1:0]    marker
);
  import stripe_pkg::*;

  logic [PAY_W-1:0] table_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign table_q[g] = marker_payload(g);
  end

  always_comb begin
    marker = {SYNC_CTRL, PAY_W'(0)};
    for (int i = 0; i < LANES; i++) begin
      if (sel == LANE_W'(i)) marker = {SYNC_CTRL, table_q[i]};
    end
  end
endmodule

// File: rtl/lane_stripe_marker.sv
module lane_stripe_marker #(
  parameter int LANES       = 20,
  parameter int MARK_PERIOD = 16384,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [stripe_pkg::BLK_W-1:0] in_block,
  output logic                         in_ready,
  output logic                         out_valid,
  output logic [LANE_W-1:0]            out_lane,
  output logic [stripe_pkg::BLK_W-1:0] out_block
);
  import stripe_pkg::*;

  logic [LANE_W-1:0] slot;
  logic              marker_phase;
  logic              advance;
  logic [BLK_W-1:0]  marker;

  assign in_ready = !marker_phase;
  assign advance  = marker_phase || in_valid;

  stripe_sequencer #(.LANES(LANES), .PERIOD(MARK_PERIOD)) u_seq (
    .clk(clk), .rst(rst), .advance(advance),
    .slot(slot), .marker_phase(marker_phase)
  );

  stripe_marker_gen #(.LANES(LANES)) u_mark (
    .sel(slot), .marker(marker)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lane  <= '0;
      out_block <= '0;
    end else begin
      out_valid <= advance;
      if (advance) begin
        out_lane  <= slot;
        out_block <= marker_phase ? marker : in_block;
      end
    end
  end
endmodule

// File: rtl/lane_stripe_marker_chk.sv
module lane_stripe_marker_chk #(
  parameter int LANES       = 20,
  parameter int MARK_PERIOD = 16384,
  localparam int LANE_W = $clog2(LANES)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [65:0]       in_block,
  input logic              in_ready,
  input logic              out_valid,
  input logic [LANE_W-1:0] out_lane,
  input logic [65:0]       out_block
);
  logic [LANE_W-1:0] prev_lane;
  logic              have_prev;
  logic [31:0]       hold_run;
  logic [31:0]       xfer_cnt;
  logic              seen_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lane <= '0;
      have_prev <= 1'b0;
      hold_run  <= '0;
      xfer_cnt  <= '0;
      seen_data <= 1'b0;
    end else begin
      if (out_valid) begin
        prev_lane <= out_lane;
        have_prev <= 1'b1;
      end
      hold_run <= in_ready ? '0 : hold_run + 1;
      if (!in_ready) xfer_cnt <= '0;
      else if (in_valid) xfer_cnt <= xfer_cnt + 1;
      if (in_ready) seen_data <= 1'b1;
    end
  end

  AST_FIRST_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && !have_prev |-> out_lane == '0); // R2

  AST_LANE_STEP: assert property (@(posedge clk) disable iff (rst)
    out_valid && have_prev |->
      out_lane == ((prev_lane == LANE_W'(LANES - 1)) ? '0 : prev_lane + 1'b1)); // R6

  AST_XFER_ECHO: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_block == $past(in_block)); // R5

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    in_ready && !in_valid |=> !out_valid); // R6

  AST_MARKER_BACK2BACK: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid && out_block[65:64] == 2'b10 && out_block[63:56] == 8'hA5); // R9

  AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    hold_run <= 32'(LANES)); // R4

  AST_PERIOD_COUNT: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) && seen_data |-> xfer_cnt == 32'(LANES * (MARK_PERIOD - 1))); // R7
endmodule

bind lane_stripe_marker lane_stripe_marker_chk #(.LANES(LANES), .MARK_PERIOD(MARK_PERIOD)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
  .in_ready(in_ready), .out_valid(out_valid), .out_lane(out_lane), .out_block(out_block)
);

// File: tb/test_lane_stripe_marker.sv
`timescale 1ns/1ps
module test_lane_stripe_marker;
  localparam int LANES  = 4;
  localparam int PERIOD = 3;
  localparam int LW     = $clog2(LANES);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [65:0]   in_block = '0;
  logic          in_ready;
  logic          out_valid;
  logic [LW-1:0] out_lane;
  logic [65:0]   out_block;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  lane_stripe_marker #(.LANES(LANES), .MARK_PERIOD(PERIOD)) i_lane_stripe_marker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
    .in_ready(in_ready), .out_valid(out_valid), .out_lane(out_lane), .out_block(out_block)
  );

  function automatic logic [65:0] exp_marker(int lane);
    logic [7:0] b;
    b = 8'(lane);
    return {2'b10, 8'hA5, b, ~b, b, ~b, b, ~b, b};
  endfunction

  // behavioural model: n counts blocks emitted since reset
  int          n = 0;
  logic        exp_valid = 1'b0;
  logic [LW-1:0] exp_lane = '0;
  logic [65:0] exp_block = '0;
  logic        exp_marker_flag = 1'b0;
  logic        exp_first_rot = 1'b0;
  logic        in_rst_window = 1'b1;

  always @(posedge clk) begin
    cycles++;
    in_rst_window = rst;
    if (rst) begin
      n = 0;
      exp_valid = 1'b0;
    end else if (((n / LANES) % PERIOD) == 0) begin
      exp_valid = 1'b1;
      exp_lane = LW'(n % LANES);
      exp_block = exp_marker(n % LANES);
      exp_marker_flag = 1'b1;
      exp_first_rot = (n < LANES);
      n++;
    end else if (in_valid) begin
      exp_valid = 1'b1;
      exp_lane = LW'(n % LANES);
      exp_block = in_block;
      exp_marker_flag = 1'b0;
      exp_first_rot = 1'b0;
      n++;
    end else begin
      exp_valid = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0) begin
      if (in_rst_window) begin
        chk(out_valid == 1'b0, "R1 out_valid", 66'(out_valid), 66'(0));
        chk(in_ready == 1'b0, "R1 in_ready", 66'(in_ready), 66'(0));
      end else begin
        chk(in_ready == (((n / LANES) % PERIOD) != 0), "R4 in_ready",
            66'(in_ready), 66'(((n / LANES) % PERIOD) != 0));
        chk(out_valid == exp_valid, exp_marker_flag ? "R9 out_valid" : "R6 out_valid",
            66'(out_valid), 66'(exp_valid));
        if (exp_valid && out_valid) begin
          chk(out_lane == exp_lane, exp_first_rot ? "R2 out_lane" : "R6 out_lane",
              66'(out_lane), 66'(exp_lane));
          chk(out_block == exp_block, exp_marker_flag ? "R3 R7 marker block" : "R5 R8 data block",
              out_block, exp_block);
        end
      end
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  int seq = 0;

  task automatic drive(input bit v);
    @(negedge clk);
    in_valid = v;
    seq++;
    in_block = {seq[0] ? 2'b01 : 2'b10, 32'hD00D0000 + 32'(seq), 32'(seq * 7)};
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 150; i++) drive(1'b1);
    for (int i = 0; i < 250; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0] | lfsr[3]);
    end
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 120; i++) drive(1'b1);
    for (int i = 0; i < 40; i++) drive(1'b0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule